// File: doc/BRIEF.md
# Persistent Request Arbiter

This block settles starvation between requesters that compete for the same memory address. A requester whose ordinary request timed out sends a persistent request here. The request carries the requester's ID, the address and a flag that marks it as a read. The arbiter keeps one table slot per requester. For each address it grants one request at a time, and it announces the grant by sending a broadcast message that names the address and the winning requester. The other requests for that address wait in the order they arrived.

When the winner has finished, it signals deactivate. The arbiter answers with a single broadcast message. That message retires the old winner and also names the next winner for the same address, if one is waiting. If nobody is waiting, the message only retires the old winner. Requests for different addresses are tracked independently, so several addresses can have an active winner at the same time. A deactivate from a requester that is not currently a winner does nothing except raise an error flag for one cycle.

Top module: `persist_arbiter`

## Requirements
- R1: After reset, bcastValid and errFlag are 0. reqReady is 1 for any requester ID while deactValid is 0.
- R2: A request accepted for an address with no stored request produces one broadcast on the next cycle. That broadcast has bcastAct=1, bcastDeact=0, bcastActProc equal to the requester, bcastAddr equal to the address and bcastRead equal to the read flag.
- R3: A request accepted for an address that already has a stored request produces no broadcast. It is queued.
- R4: A deactivate from the active winner of an address that has no waiting requests gives, on the next cycle, bcastDeact=1, bcastAct=0, bcastDeactProc equal to the winner and bcastAddr equal to its address.
- R5: A deactivate from the active winner of an address that has waiting requests gives, on the next cycle, one broadcast with bcastDeact=1 and bcastAct=1. bcastActProc is the waiting request that arrived first, whatever its ID, and bcastRead is that request's flag.
- R6: A deactivate from a requester that is not an active winner, whether it is queued or idle, produces no broadcast and sets errFlag for exactly one cycle. It does not change any stored state.
- R7: reqReady is 0 when the requester named by reqProc already holds a stored request, and it is 0 in any cycle where deactValid is 1.
- R8: A request for a different address is activated at once, even while another address has an active winner and a queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Persistent request present |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqProc | input | PID_W | Requester ID |
| reqAddr | input | ADDR_W | Address being requested |
| reqRead | input | 1 | 1 = read request, 0 = write request |
| deactValid | input | 1 | Deactivate present |
| deactProc | input | PID_W | Requester sending the deactivate |
| bcastValid | output | 1 | Broadcast message valid |
| bcastAct | output | 1 | Message activates bcastActProc |
| bcastDeact | output | 1 | Message retires bcastDeactProc |
| bcastActProc | output | PID_W | New winner |
| bcastDeactProc | output | PID_W | Retired winner |
| bcastAddr | output | ADDR_W | Address the message refers to |
| bcastRead | output | 1 | Read flag of the new winner |
| errFlag | output | 1 | One-cycle pulse on a deactivate from a non-winner |

## Verification
The bench queues two requests behind a winner. The later arrival has the lower ID, so a design that picks by ID instead of by arrival names the wrong next winner at handoff. The bench sends deactivates from a queued requester and from an idle requester. A design that accepts either one would broadcast a retirement and corrupt the order of the queue. The bench also activates a second address while the first one is busy, which catches a design that serializes every address. Finally it drains both queues completely, which catches a handoff message that wrongly sets bcastAct when the queue is empty.

// File: rtl/pra_pkg.sv
package pra_pkg;
  typedef struct packed {
    logic accept;
    logic activateNew;
    logic retire;
    logic activateNext;
    logic flagErr;
  } pra_strobe_t;
endpackage

// File: rtl/pra_datapath.sv
module pra_datapath
  import pra_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int ADDR_W = 16,
  localparam int PID_W = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  pra_strobe_t       strb,
  input  logic [PID_W-1:0]  reqProc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqRead,
  input  logic [PID_W-1:0]  deactProc,
  output logic              procBusy,
  output logic              addrBusy,
  output logic              deactIsWinner,
  output logic              nextFound,
  output logic              bcastValid,
  output logic              bcastAct,
  output logic              bcastDeact,
  output logic [PID_W-1:0]  bcastActProc,
  output logic [PID_W-1:0]  bcastDeactProc,
  output logic [ADDR_W-1:0] bcastAddr,
  output logic              bcastRead,
  output logic              errFlag
);
  logic [NUM_PROC-1:0]  slotValid;
  logic [NUM_PROC-1:0]  slotActive;
  logic [NUM_PROC-1:0]  slotRead;
  logic [ADDR_W-1:0]    slotAddr [NUM_PROC];
  logic [NUM_PROC-1:0]  olderThan [NUM_PROC];
  logic [NUM_PROC-1:0]  cand;
  logic [NUM_PROC-1:0]  oldest;
  logic [PID_W-1:0]     nextIdx;
  logic [ADDR_W-1:0]    retireAddr;

  assign procBusy      = slotValid[reqProc];
  assign deactIsWinner = slotValid[deactProc] && slotActive[deactProc];
  assign retireAddr    = slotAddr[deactProc];

  always_comb begin
    addrBusy = 1'b0;
    for (int i = 0; i < NUM_PROC; i++)
      if (slotValid[i] && slotAddr[i] == reqAddr) addrBusy = 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NUM_PROC; i++)
      cand[i] = slotValid[i] && !slotActive[i] && (slotAddr[i] == retireAddr)
                && (PID_W'(i) != deactProc);
  end

  always_comb begin
    for (int i = 0; i < NUM_PROC; i++) begin
      oldest[i] = cand[i];
      for (int j = 0; j < NUM_PROC; j++)
        if (j != i && cand[j] && !olderThan[i][j]) oldest[i] = 1'b0;
    end
  end

  always_comb begin
    nextFound = 1'b0;
    nextIdx   = '0;
    for (int i = NUM_PROC - 1; i >= 0; i--)
      if (oldest[i]) begin
        nextFound = 1'b1;
        nextIdx   = PID_W'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slotValid  <= '0;
      slotActive <= '0;
      slotRead   <= '0;
      for (int i = 0; i < NUM_PROC; i++) begin
        slotAddr[i]  <= '0;
        olderThan[i] <= '0;
      end
    end else begin
      if (strb.accept) begin
        slotValid[reqProc]  <= 1'b1;
        slotActive[reqProc] <= strb.activateNew;
        slotRead[reqProc]   <= reqRead;
        slotAddr[reqProc]   <= reqAddr;
        for (int i = 0; i < NUM_PROC; i++) begin
          if (PID_W'(i) != reqProc) olderThan[i][reqProc] <= slotValid[i];
          olderThan[reqProc][i] <= 1'b0;
        end
      end
      if (strb.retire) begin
        slotValid[deactProc]  <= 1'b0;
        slotActive[deactProc] <= 1'b0;
      end
      if (strb.activateNext) slotActive[nextIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bcastValid     <= 1'b0;
      bcastAct       <= 1'b0;
      bcastDeact     <= 1'b0;
      bcastActProc   <= '0;
      bcastDeactProc <= '0;
      bcastAddr      <= '0;
      bcastRead      <= 1'b0;
      errFlag        <= 1'b0;
    end else begin
      bcastValid     <= strb.activateNew || strb.retire;
      bcastAct       <= strb.activateNew || strb.activateNext;
      bcastDeact     <= strb.retire;
      bcastActProc   <= strb.activateNew ? reqProc : nextIdx;
      bcastDeactProc <= deactProc;
      bcastAddr      <= strb.retire ? retireAddr : reqAddr;
      bcastRead      <= strb.activateNew ? reqRead : slotRead[nextIdx];
      errFlag        <= strb.flagErr;
    end
  end
endmodule

// File: rtl/pra_ctrl.sv
module pra_ctrl
  import pra_pkg::*;
(
  input  logic        reqValid,
  input  logic        deactValid,
  input  logic        procBusy,
  input  logic        addrBusy,
  input  logic        deactIsWinner,
  input  logic        nextFound,
  output logic        reqReady,
  output pra_strobe_t strb
);
  always_comb begin
    reqReady          = !procBusy && !deactValid;
    strb.accept       = reqValid && reqReady;
    strb.activateNew  = strb.accept && !addrBusy;
    strb.retire       = deactValid && deactIsWinner;
    strb.activateNext = strb.retire && nextFound;
    strb.flagErr      = deactValid && !deactIsWinner;
  end
endmodule

// File: rtl/persist_arbiter.sv
module persist_arbiter
  import pra_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int ADDR_W = 16,
  localparam int PID_W = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [PID_W-1:0]  reqProc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqRead,
  input  logic              deactValid,
  input  logic [PID_W-1:0]  deactProc,
  output logic              bcastValid,
  output logic              bcastAct,
  output logic              bcastDeact,
  output logic [PID_W-1:0]  bcastActProc,
  output logic [PID_W-1:0]  bcastDeactProc,
  output logic [ADDR_W-1:0] bcastAddr,
  output logic              bcastRead,
  output logic              errFlag
);
  pra_strobe_t strb;
  logic procBusy, addrBusy, deactIsWinner, nextFound;

  pra_ctrl u_ctrl (
    .reqValid(reqValid), .deactValid(deactValid), .procBusy(procBusy),
    .addrBusy(addrBusy), .deactIsWinner(deactIsWinner), .nextFound(nextFound),
    .reqReady(reqReady), .strb(strb)
  );

  pra_datapath #(.NUM_PROC(NUM_PROC), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .reqProc(reqProc), .reqAddr(reqAddr),
    .reqRead(reqRead), .deactProc(deactProc), .procBusy(procBusy),
    .addrBusy(addrBusy), .deactIsWinner(deactIsWinner), .nextFound(nextFound),
    .bcastValid(bcastValid), .bcastAct(bcastAct), .bcastDeact(bcastDeact),
    .bcastActProc(bcastActProc), .bcastDeactProc(bcastDeactProc),
    .bcastAddr(bcastAddr), .bcastRead(bcastRead), .errFlag(errFlag)
  );
endmodule

// File: rtl/pra_checker.sv
module pra_checker #(
  parameter int NUM_PROC = 4,
  parameter int ADDR_W = 16,
  localparam int PID_W = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic [PID_W-1:0]  reqProc,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqRead,
  input logic              deactValid,
  input logic [PID_W-1:0]  deactProc,
  input logic              bcastValid,
  input logic              bcastAct,
  input logic              bcastDeact,
  input logic [PID_W-1:0]  bcastActProc,
  input logic [PID_W-1:0]  bcastDeactProc,
  input logic [ADDR_W-1:0] bcastAddr,
  input logic              bcastRead,
  input logic              errFlag
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!bcastValid && !errFlag));

  // R7
  deact_blocks_req_chk: assert property (@(posedge clk) disable iff (rst)
    deactValid |-> !reqReady);

  // R6
  err_no_bcast_chk: assert property (@(posedge clk) disable iff (rst)
    errFlag |-> !bcastValid);

  // R6
  err_from_deact_chk: assert property (@(posedge clk) disable iff (rst)
    errFlag |-> $past(deactValid));

  // R4
  deact_from_input_chk: assert property (@(posedge clk) disable iff (rst)
    bcastDeact |-> ($past(deactValid) && bcastDeactProc == $past(deactProc)));

  // R2
  lone_act_from_req_chk: assert property (@(posedge clk) disable iff (rst)
    (bcastAct && !bcastDeact) |->
      ($past(reqValid && reqReady) && bcastActProc == $past(reqProc)
       && bcastAddr == $past(reqAddr)));

  // R5
  handoff_distinct_chk: assert property (@(posedge clk) disable iff (rst)
    (bcastAct && bcastDeact) |-> (bcastActProc != bcastDeactProc));

  // R2
  valid_has_kind_chk: assert property (@(posedge clk) disable iff (rst)
    bcastValid |-> (bcastAct || bcastDeact));
endmodule

bind persist_arbiter pra_checker #(.NUM_PROC(NUM_PROC), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_persist_arbiter.sv
module tb_persist_arbiter;
  localparam int NP = 4;
  localparam int AW = 16;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqRead = 1'b0, deactValid = 1'b0;
  logic [PW-1:0] reqProc = '0, deactProc = '0;
  logic [AW-1:0] reqAddr = '0;
  logic reqReady, bcastValid, bcastAct, bcastDeact, bcastRead, errFlag;
  logic [PW-1:0] bcastActProc, bcastDeactProc;
  logic [AW-1:0] bcastAddr;
  logic readySeen;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  persist_arbiter #(.NUM_PROC(NP), .ADDR_W(AW)) dut (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // one cycle of stimulus; outputs are sampled 1 ns after the edge
  task automatic step(logic rv, logic [PW-1:0] rp, logic [AW-1:0] ra, logic rr,
                      logic dv, logic [PW-1:0] dp);
    @(negedge clk);
    reqValid = rv; reqProc = rp; reqAddr = ra; reqRead = rr;
    deactValid = dv; deactProc = dp;
    #1 readySeen = reqReady;
    @(posedge clk);
    #1;
    reqValid = 1'b0; deactValid = 1'b0;
  endtask

  task automatic expectMsg(string tag, logic v, logic a, logic d, logic [PW-1:0] ap,
                           logic [PW-1:0] dp, logic [AW-1:0] ad, logic rd);
    chk({tag, " valid"}, 32'(bcastValid), 32'(v));
    chk({tag, " act"}, 32'(bcastAct), 32'(a));
    chk({tag, " deact"}, 32'(bcastDeact), 32'(d));
    if (a) chk({tag, " actProc"}, 32'(bcastActProc), 32'(ap));
    if (d) chk({tag, " deactProc"}, 32'(bcastDeactProc), 32'(dp));
    if (v) chk({tag, " addr"}, 32'(bcastAddr), 32'(ad));
    if (a) chk({tag, " read"}, 32'(bcastRead), 32'(rd));
  endtask

  task automatic testReset();
    chk("R1 bcastValid", 32'(bcastValid), 0);
    chk("R1 errFlag", 32'(errFlag), 0);
    step(0, 2'd2, 16'h0, 0, 0, 0);
    chk("R1 reqReady", 32'(readySeen), 1);
  endtask

  task automatic testIdleActivate();
    step(1, 2'd1, 16'h0010, 0, 0, 0);
    expectMsg("R2 first", 1, 1, 0, 2'd1, 0, 16'h0010, 0);
  endtask

  task automatic testQueue();
    step(1, 2'd3, 16'h0010, 1, 0, 0);
    expectMsg("R3 q1", 0, 0, 0, 0, 0, 0, 0);
    step(1, 2'd0, 16'h0010, 0, 0, 0);
    expectMsg("R3 q2", 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic testReady();
    step(1, 2'd3, 16'h0055, 0, 0, 0);
    chk("R7 busy proc", 32'(readySeen), 0);
    chk("R7 busy proc no bcast", 32'(bcastValid), 0);
    step(0, 2'd2, 16'h0, 0, 1, 2'd3);
    chk("R7 deact blocks", 32'(readySeen), 0);
    step(0, 2'd0, 16'h0, 0, 0, 0);
  endtask

  task automatic testBadDeact();
    step(0, 0, 0, 0, 1, 2'd3);
    expectMsg("R6 queued", 0, 0, 0, 0, 0, 0, 0);
    chk("R6 err queued", 32'(errFlag), 1);
    step(0, 0, 0, 0, 0, 0);
    chk("R6 err one cycle", 32'(errFlag), 0);
    step(0, 0, 0, 0, 1, 2'd2);
    chk("R6 err idle", 32'(errFlag), 1);
    chk("R6 idle no bcast", 32'(bcastValid), 0);
  endtask

  task automatic testHandoff();
    step(0, 0, 0, 0, 1, 2'd1);
    expectMsg("R5 first handoff", 1, 1, 1, 2'd3, 2'd1, 16'h0010, 1);
    chk("R6 no err on winner", 32'(errFlag), 0);
  endtask

  task automatic testOtherAddr();
    step(1, 2'd2, 16'h0020, 1, 0, 0);
    expectMsg("R8 other addr", 1, 1, 0, 2'd2, 0, 16'h0020, 1);
  endtask

  task automatic testDrain();
    step(0, 0, 0, 0, 1, 2'd3);
    expectMsg("R5 second handoff", 1, 1, 1, 2'd0, 2'd3, 16'h0010, 0);
    step(0, 0, 0, 0, 1, 2'd0);
    expectMsg("R4 empty 0x10", 1, 0, 1, 0, 2'd0, 16'h0010, 0);
    step(0, 0, 0, 0, 1, 2'd2);
    expectMsg("R4 empty 0x20", 1, 0, 1, 0, 2'd2, 16'h0020, 0);
    step(1, 2'd1, 16'h0010, 1, 0, 0);
    chk("R7 freed ready", 32'(readySeen), 1);
    expectMsg("R2 reuse", 1, 1, 0, 2'd1, 0, 16'h0010, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    testReset();
    testIdleActivate();
    testQueue();
    testReady();
    testBadDeact();
    testHandoff();
    testOtherAddr();
    testDrain();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule